// File: doc/BRIEF.md
# Two-Line Direct-Mapped Write-Through Data Cache

This block is a very small data cache placed between a processor word port and a word-wide main-memory port. It holds two lines of four 32-bit words. Each address maps to exactly one line. Processor addresses are word-aligned byte addresses, split into three fields:
- bits [3:2] pick the word inside the line;
- bit 4 picks the line;
- the remaining upper bits form the tag.

Every write goes through to memory. A write that misses first fetches the whole line, then merges its word into the line, and is then forwarded to memory. Because no line is ever dirty, a line that is replaced is overwritten without any write-back.

The processor side is a valid/ready request channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when the cache is idle, so at most one access is in flight. The cache does not hold `rsp_valid` for the requester: it is a one-cycle strobe that cannot be stalled. It carries the read data and the hit/miss flag for that access.

The memory side uses a request/acknowledge handshake, one word per handshake:
- `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until a cycle with `mem_ack` high;
- `mem_rdata` is taken in that same ack cycle.

Four saturating counters tally read hits, read misses, write hits and write misses.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid, all four counters read zero, `req_ready` is high, and the first access to each line reports a miss.
- R2: An access hits exactly when its line (address bit 4) is valid and the stored tag equals address bits [15:5]; address bits [3:2] choose the word.
- R3: A read hit raises `rsp_valid` with `rsp_hit`=1 and the word in the first cycle after acceptance, and issues no memory transfer.
- R4: A read miss issues four memory reads at the line-aligned address, in ascending word order (base, base+4, base+8, base+12), then responds with `rsp_hit`=0 and the word as held in memory.
- R5: A write hit updates the cached word and issues exactly one memory write of that word at the request address; the response follows that write's acknowledge, and later reads return the new value.
- R6: A write miss performs the four-read line fill, merges the written word, forwards it with one memory write, and leaves the line valid so that a following read of any word in it hits.
- R7: A line that is replaced by a conflicting tag is overwritten with no memory write; a read never causes a memory write.
- R8: `req_ready` is low from the cycle after acceptance until the response cycle inclusive, and is high again in the cycle after `rsp_valid`.
- R9: Each accepted access yields exactly one `rsp_valid` pulse, one cycle long.
- R10: On each response, exactly one counter advances by one. The counter is picked by {write, miss}: 0 read hit, 1 read miss, 2 write hit, 3 write miss. Each counter stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word-aligned byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_hit | output | 1 | 1 = hit, 0 = miss; meaningful with rsp_valid |
| rsp_rdata | output | 32 | Read data; meaningful with rsp_valid on reads |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 16 | Memory byte address, word-aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current transfer |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| cnt_rd_hit | output | 8 | Saturating read-hit count |
| cnt_rd_miss | output | 8 | Saturating read-miss count |
| cnt_wr_hit | output | 8 | Saturating write-hit count |
| cnt_wr_miss | output | 8 | Saturating write-miss count |

## Verification
The assertions assume the following about the inputs:
- the memory raises `mem_ack` only while `mem_req` is high;
- every processor address is word-aligned.

The fill-order and request-hold properties depend on these assumptions. The stimulus stays inside them in two ways. The bench memory answers only a pending request, after a random wait of zero to two cycles. Every address is built as a word index times four, inside a 256-byte window.

The stimulus has three parts:
- a replay of a 4x4 transpose, with source at byte 0 and destination at byte 64, so that the two arrays keep evicting each other's lines;
- directed write-hit, write-miss and saturation cases;
- a fixed-seed random mix of reads and writes.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_FILL,
    S_FINISH,
    S_WRITE
  } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 11,
  parameter int LINES  = 2,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 1,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_set,
  input  logic              tag_clr,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [TAG_W-1:0]  tag_val
);
  logic [DATA_W-1:0] data_q [LINES][WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx][wr_word] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (tag_set) begin
      valid_q[tag_idx] <= 1'b1;
      tag_q[tag_idx]   <= tag_val;
    end else if (tag_clr) begin
      valid_q[tag_idx] <= 1'b0;
    end
  end

  assign rd_data  = data_q[rd_idx][rd_word];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  p_tag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_set && tag_clr));
  p_set_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tag_set |=> valid_q[$past(tag_idx)]);
endmodule

// File: rtl/wtc_sat_cnt.sv
module wtc_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc && count != MAXV) count <= count + 1'b1;
  end

  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count == MAXV |=> count == MAXV);
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != MAXV) |=> count == W'($past(count) + 1'b1));
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 11,
  parameter int IDX_W  = 1,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_we,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [WSEL_W-1:0] rd_word,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              rd_valid,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WSEL_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data,
  output logic              tag_set,
  output logic              tag_clr,
  output logic [IDX_W-1:0]  tag_idx,
  output logic [TAG_W-1:0]  tag_val
);
  localparam int OFF_W = WSEL_W + 2;
  localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(WORDS - 1);

  wtc_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              hit_q;
  logic [WSEL_W-1:0] fill_cnt;

  logic [TAG_W-1:0]  tag_a;
  logic [IDX_W-1:0]  idx_a;
  logic [WSEL_W-1:0] word_a;
  logic              hit;

  assign tag_a  = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_a  = addr_q[OFF_W +: IDX_W];
  assign word_a = addr_q[2 +: WSEL_W];
  assign hit    = rd_valid && (rd_tag == tag_a);

  assign rd_idx    = idx_a;
  assign rd_word   = word_a;
  assign wr_idx    = idx_a;
  assign tag_idx   = idx_a;
  assign tag_val   = tag_a;
  assign req_ready = (state == S_IDLE);
  assign rsp_we    = we_q;
  assign mem_wdata = wdata_q;

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = addr_q;
    wr_en    = 1'b0;
    wr_word  = word_a;
    wr_data  = wdata_q;
    tag_set  = 1'b0;
    tag_clr  = 1'b0;
    unique case (state)
      S_LOOK: begin
        if (hit && we_q) wr_en = 1'b1;
        if (!hit) tag_clr = 1'b1;
      end
      S_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {tag_a, idx_a, fill_cnt, 2'b00};
        if (mem_ack) begin
          wr_en   = 1'b1;
          wr_word = fill_cnt;
          wr_data = mem_rdata;
          tag_set = (fill_cnt == LAST_W);
        end
      end
      S_FINISH: wr_en = we_q;
      S_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  assign rsp_valid = (state == S_LOOK && hit && !we_q)
                   || (state == S_FINISH && !we_q)
                   || (state == S_WRITE && mem_ack);
  assign rsp_hit   = (state == S_LOOK) ? hit : hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      hit_q    <= 1'b0;
      fill_cnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          we_q    <= req_we;
          state   <= S_LOOK;
        end
        S_LOOK: begin
          hit_q    <= hit;
          fill_cnt <= '0;
          if (!hit)     state <= S_FILL;
          else if (we_q) state <= S_WRITE;
          else          state <= S_IDLE;
        end
        S_FILL: if (mem_ack) begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == LAST_W) state <= S_FINISH;
        end
        S_FINISH: state <= we_q ? S_WRITE : S_IDLE;
        S_WRITE: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_fill_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_ack && fill_cnt != LAST_W)
      |=> mem_addr == ADDR_W'($past(mem_addr) + 4));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int KINDS  = 4;

  logic              rsp_we;
  logic [IDX_W-1:0]  rd_idx, wr_idx, tag_idx;
  logic [WSEL_W-1:0] rd_word, wr_word;
  logic [TAG_W-1:0]  rd_tag, tag_val;
  logic              rd_valid, wr_en, tag_set, tag_clr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  cnt_v [KINDS];

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
    .TAG_W(TAG_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_we(rsp_we),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_data(wr_data),
    .tag_set(tag_set), .tag_clr(tag_clr), .tag_idx(tag_idx), .tag_val(tag_val)
  );

  wtc_line_store #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .LINES(LINES), .WORDS(WORDS),
    .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(rsp_rdata),
    .rd_tag(rd_tag), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_data(wr_data),
    .tag_set(tag_set), .tag_clr(tag_clr), .tag_idx(tag_idx), .tag_val(tag_val)
  );

  for (genvar g = 0; g < KINDS; g++) begin : g_cnt
    logic bump;
    assign bump = rsp_valid && ({rsp_we, !rsp_hit} == 2'(g));
    wtc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(bump), .count(cnt_v[g])
    );
  end

  assign cnt_rd_hit  = cnt_v[0];
  assign cnt_rd_miss = cnt_v[1];
  assign cnt_wr_hit  = cnt_v[2];
  assign cnt_wr_miss = cnt_v[3];
endmodule

// File: tb/sim_dm_wt_cache.sv
module sim_dm_wt_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0]  cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dm_wt_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
    .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss)
  );

  // bench memory and traffic log
  logic [31:0] mem_m [64];
  logic [15:0] rd_log [8];
  int          rd_n = 0, wr_n = 0;
  logic [15:0] wr_addr_seen = '0;

  // reference cache state and counters
  bit          ref_valid [2];
  logic [10:0] ref_tag [2];
  int          exp_cnt [4];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  initial begin
    int dly;
    dly = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        if (dly == 0) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem_m[mem_addr[7:2]] = mem_wdata;
            wr_n++;
            wr_addr_seen = mem_addr;
          end else begin
            mem_rdata = mem_m[mem_addr[7:2]];
            if (rd_n < 8) rd_log[rd_n] = mem_addr;
            rd_n++;
          end
          dly = int'($urandom % 3);
        end else begin
          dly--;
        end
      end
    end
  end

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [31:0] d);
    bit          exp_hit, busy_bad;
    int          lat, idx, kind;
    logic [31:0] exp_rd;
    logic [15:0] base;
    idx     = int'(a[4]);
    exp_hit = ref_valid[idx] && (ref_tag[idx] == a[15:5]);
    exp_rd  = mem_m[a[7:2]];
    base    = {a[15:4], 4'h0};
    @(negedge clk);
    rd_n = 0;
    wr_n = 0;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    sample();
    req_valid = 1'b0;
    lat = 1;
    busy_bad = 1'b0;
    while (!rsp_valid && lat < 200) begin
      if (req_ready) busy_bad = 1'b1;
      sample();
      lat++;
    end
    if (req_ready) busy_bad = 1'b1;
    chk(rsp_valid, "R9", "response seen", 32'(rsp_valid), 1);
    chk(!busy_bad, "R8", "ready low while busy", 32'(busy_bad), 0);
    chk(rsp_hit == exp_hit, exp_hit ? "R2" : "R1", "hit flag", 32'(rsp_hit), 32'(exp_hit));
    if (!we) begin
      chk(rsp_rdata == exp_rd, exp_hit ? "R3" : "R4", "read data", rsp_rdata, exp_rd);
      chk(wr_n == 0, "R7", "no memory write on read", 32'(wr_n), 0);
    end
    if (!we && exp_hit) chk(lat == 1, "R3", "hit latency", 32'(lat), 1);
    if (exp_hit) chk(rd_n == 0, "R3", "no fill on hit", 32'(rd_n), 0);
    else begin
      chk(rd_n == 4, we ? "R6" : "R4", "fill length", 32'(rd_n), 4);
      for (int k = 0; k < 4; k++)
        chk(rd_log[k] == base + 16'(4 * k), we ? "R6" : "R4", "fill address",
            32'(rd_log[k]), 32'(base + 16'(4 * k)));
    end
    if (we) begin
      chk(wr_n == 1 && wr_addr_seen == a, exp_hit ? "R5" : "R6", "write forwarded",
          32'(wr_addr_seen), 32'(a));
      chk(mem_m[a[7:2]] == d, exp_hit ? "R5" : "R6", "memory word", mem_m[a[7:2]], d);
    end
    sample();
    chk(!rsp_valid, "R9", "single pulse", 32'(rsp_valid), 0);
    chk(req_ready, "R8", "ready after response", 32'(req_ready), 1);
    ref_valid[idx] = 1'b1;
    ref_tag[idx]   = a[15:5];
    kind = (we ? 2 : 0) + (exp_hit ? 0 : 1);
    if (exp_cnt[kind] < 255) exp_cnt[kind]++;
  endtask

  task automatic chk_counts(input string what);
    chk(cnt_rd_hit  == 8'(exp_cnt[0]), "R10", {what, " read hits"},  32'(cnt_rd_hit),  32'(exp_cnt[0]));
    chk(cnt_rd_miss == 8'(exp_cnt[1]), "R10", {what, " read misses"}, 32'(cnt_rd_miss), 32'(exp_cnt[1]));
    chk(cnt_wr_hit  == 8'(exp_cnt[2]), "R10", {what, " write hits"}, 32'(cnt_wr_hit),  32'(exp_cnt[2]));
    chk(cnt_wr_miss == 8'(exp_cnt[3]), "R10", {what, " write misses"}, 32'(cnt_wr_miss), 32'(exp_cnt[3]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 64; k++) mem_m[k] = 32'hA500_0000 + 32'(k * 3);
    for (int k = 0; k < 2; k++) begin ref_valid[k] = 1'b0; ref_tag[k] = '0; end
    for (int k = 0; k < 4; k++) exp_cnt[k] = 0;
    repeat (3) @(posedge clk);
    sample();
    rst_n = 1'b1;
    sample();
    // R1: reset state
    chk(req_ready, "R1", "ready after reset", 32'(req_ready), 1);
    chk(!rsp_valid && !mem_req, "R1", "quiet after reset", 32'({rsp_valid, mem_req}), 0);
    chk_counts("R1 reset");

    // transpose trace: source at 0, destination at 64 share lines
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        logic [31:0] v;
        v = mem_m[i * 4 + j];
        access(1'b0, 16'((i * 4 + j) * 4), 32'h0);
        access(1'b1, 16'(64 + (j * 4 + i) * 4), v);
      end
    chk_counts("transpose");

    // R5 write hit then read back; R6 write miss then neighbour read hits
    access(1'b0, 16'h0080, 32'h0);
    access(1'b1, 16'h0084, 32'h1234_5678);
    access(1'b0, 16'h0084, 32'h0);
    access(1'b1, 16'h00B8, 32'hCAFE_0001);
    access(1'b0, 16'h00B0, 32'h0);
    access(1'b0, 16'h00B8, 32'h0);
    // R7 conflicting tag evicts, then old line misses again
    access(1'b0, 16'h0018, 32'h0);
    access(1'b0, 16'h00B4, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] w;
      w = 6'($urandom % 64);
      access(1'($urandom % 2), {8'h0, w, 2'b00}, $urandom);
    end
    chk_counts("random");

    // R10 saturation of the read-hit counter
    for (int n = 0; n < 270; n++) access(1'b0, 16'h0040, 32'h0);
    chk_counts("saturation");
    chk(cnt_rd_hit == 8'hFF, "R10", "read-hit counter pinned", 32'(cnt_rd_hit), 32'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule